// File: doc/BRIEF.md
# Byte-lane system control register file

This block is a bank of sixteen 16-bit register slots sitting on a word-addressed I/O bus that carries both word and byte writes. A request presents a byte address; bits 4:1 choose the slot and bit 0 picks the odd or even byte of a byte access. Reads return data in the same cycle as the request. Writes update state at the next rising clock edge. Any access to a slot that has no register behind it, and any write to a slot that can only be read, is answered with a non-existent-memory flag.

Each writable register handles byte writes under one of three policies. Merge replaces only the addressed byte. Shift-to-high stores an odd-byte write in the upper byte and clears the lower byte. Ignore accepts an odd-byte write and changes nothing. Byte data always travels on `wdata[7:0]`. Two error registers are set from status inputs and cleared by the bus: the memory error register by write-one-to-clear, the CPU error register by any write. A hit/miss register is loaded from the cache side. Fixed slots report the memory size and a system identifier.

Top module: `sysreg_bank`

## Requirements
- R1: The slot is `addr[4:1]`. Slots 6, 7 and 15 have no register: any request to them raises `nxm`, and `rdata` reads 0.
- R2: Slots 0, 1, 8, 9 and 10 are read-only. A write to any of them raises `nxm` and changes nothing. Reads of slots 0, 1 and 9 return 0 with `nxm` low.
- R3: The cache control register (slot 3, on `ccr_out`) uses merge. A byte write with `addr[0]`=1 replaces bits 15:8 and keeps bits 7:0. A byte write with `addr[0]`=0 replaces bits 7:0 and keeps bits 15:8.
- R4: The interrupt request register (slot 13, on `pirq_out`) uses shift-to-high. An odd byte write stores `{byte,8'h00}`, an even byte write stores `{8'h00,byte}`, and a word write stores `wdata`.
- R5: The microbreak register (slot 12) uses ignore. An odd byte write is accepted (`nxm` low) and leaves the value unchanged. An even byte write stores `{8'h00,byte}`, and a word write stores `wdata`.
- R6: The memory error register (slot 2) ORs in `mem_err_set` every cycle. A write clears exactly the bits set in the write value, and that write value is formed by the shift-to-high rule.
- R7: The CPU error register (slot 11) ORs in `cpu_err_set` every cycle. Any write to it clears it, and bits set in the same cycle survive.
- R8: The hit/miss register (slot 5) loads `hm_value` when `hm_load` is high. Writes to slot 5 and to the maintenance slot 4 are accepted with no effect, and slot 4 reads 0.
- R9: The stack limit register (slot 14, on `stklim_out`) keeps only bits 15:8 of its shift-to-high write value. Its bits 7:0 always read 0.
- R10: Slot 8 reads `(MEM_BYTES >> 6) - 1`, which is 16'h0FFF by default. Slot 10 reads the `SYS_ID` parameter, which is 16'h1234 by default.
- R11: A synchronous active-low reset clears every register. The system ID is not a stored register and is unaffected. `nxm` stays low whenever `req` is low.
- R12: A write becomes visible on `rdata` in the cycle after it is presented. The read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus request valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| byte_acc | input | 1 | 1 = byte write, 0 = word |
| addr | input | 5 | Byte address; bits 4:1 slot, bit 0 odd byte |
| wdata | input | 16 | Write data; byte data in bits 7:0 |
| rdata | output | 16 | Read data, same cycle as request |
| nxm | output | 1 | Non-existent-memory response |
| mem_err_set | input | 16 | Memory error bits to set |
| cpu_err_set | input | 16 | CPU error bits to set |
| hm_load | input | 1 | Load hit/miss register |
| hm_value | input | 16 | Hit/miss value to load |
| ccr_out | output | 16 | Cache control register |
| pirq_out | output | 16 | Interrupt request register |
| stklim_out | output | 16 | Stack limit register |

## Verification
The hardest case to reach is an error register receiving a bus write in the same cycle that its set input raises new bits. This is the only situation that separates clear-then-set from set-then-clear. A random stream rarely lines it up with a write to slot 2 or slot 11, so directed steps force both events into one cycle. The random stream also keeps the set inputs sparse, so that write-one-to-clear patterns act on a register that is non-zero. Odd byte writes to the ignore-policy slot are interleaved with reads of the same slot, which shows that the value held steady.

// File: rtl/sysreg_pkg.sv
// Shared types for the system register bank: byte-write policies and slot numbers.
// Assumes 16-bit registers and a 4-bit slot index taken from addr[4:1].
package sysreg_pkg;
    typedef enum logic [1:0] {
        POL_MERGE  = 2'd0,
        POL_SHIFT  = 2'd1,
        POL_IGNORE = 2'd2
    } byte_pol_e;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned SLOT_W = 4;
    localparam int unsigned NSLOT  = 1 << SLOT_W;

    localparam logic [SLOT_W-1:0] S_LOERR  = 4'd0;
    localparam logic [SLOT_W-1:0] S_HIERR  = 4'd1;
    localparam logic [SLOT_W-1:0] S_MEMERR = 4'd2;
    localparam logic [SLOT_W-1:0] S_CCTL   = 4'd3;
    localparam logic [SLOT_W-1:0] S_MAINT  = 4'd4;
    localparam logic [SLOT_W-1:0] S_HITMS  = 4'd5;
    localparam logic [SLOT_W-1:0] S_LOSIZE = 4'd8;
    localparam logic [SLOT_W-1:0] S_HISIZE = 4'd9;
    localparam logic [SLOT_W-1:0] S_SYSID  = 4'd10;
    localparam logic [SLOT_W-1:0] S_CPUERR = 4'd11;
    localparam logic [SLOT_W-1:0] S_UBRK   = 4'd12;
    localparam logic [SLOT_W-1:0] S_IRQ    = 4'd13;
    localparam logic [SLOT_W-1:0] S_STKLIM = 4'd14;

    localparam logic [NSLOT-1:0] READ_MAP  = 16'b0111_1111_0011_1111;
    localparam logic [NSLOT-1:0] WRITE_MAP = 16'b0111_1000_0011_1100;
endpackage

// File: rtl/sysreg_lane.sv
// Forms the next value of one register from a bus write under a fixed byte policy.
// Assumes byte data arrives on wdata[7:0]; purely combinational.
module sysreg_lane
    import sysreg_pkg::*;
#(
    parameter byte_pol_e POLICY = POL_MERGE,
    parameter int unsigned W    = REG_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic         byte_acc,
    input  logic         odd,
    output logic [W-1:0] nxt
);
    localparam int unsigned HB = W / 2;

    generate
        if (POLICY == POL_MERGE) begin : g_merge
            // Replace only the addressed byte.
            always_comb begin
                if (!byte_acc)  nxt = wdata;
                else if (odd)   nxt = {wdata[HB-1:0], cur[HB-1:0]};
                else            nxt = {cur[W-1:HB], wdata[HB-1:0]};
            end
        end else if (POLICY == POL_SHIFT) begin : g_shift
            // Odd byte lands in the upper half, other half zero.
            always_comb begin
                if (!byte_acc)  nxt = wdata;
                else if (odd)   nxt = {wdata[HB-1:0], {HB{1'b0}}};
                else            nxt = {{HB{1'b0}}, wdata[HB-1:0]};
            end
        end else begin : g_ignore
            // Odd byte dropped, even byte zero-extended.
            always_comb begin
                if (!byte_acc)  nxt = wdata;
                else if (odd)   nxt = cur;
                else            nxt = {{HB{1'b0}}, wdata[HB-1:0]};
            end
        end
    endgenerate
endmodule

// File: rtl/sysreg_decode.sv
// Decodes a bus request into per-slot write strobes and the non-existent-memory flag.
// Assumes the read and write maps from the package; combinational.
module sysreg_decode
    import sysreg_pkg::*;
(
    input  logic              req,
    input  logic              wr,
    input  logic [SLOT_W-1:0] slot,
    output logic [NSLOT-1:0]  wstb,
    output logic              nxm
);
    // Slot present for this direction of access.
    logic present;
    always_comb present = wr ? WRITE_MAP[slot] : READ_MAP[slot];

    // Error response for any request that finds nothing.
    always_comb nxm = req && !present;

    genvar i;
    generate
        for (i = 0; i < NSLOT; i++) begin : g_stb
            if (WRITE_MAP[i]) begin : g_on
                // Strobe only for an accepted write to this slot.
                assign wstb[i] = req && wr && (slot == SLOT_W'(i));
            end else begin : g_off
                assign wstb[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/sysreg_bank.sv
// System control register bank: sixteen slots, byte-lane write policies,
// error registers with set inputs and bus clears, fixed size and ID slots.
// Assumes a synchronous active-low reset and same-cycle read data.
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int unsigned  MEM_BYTES = 262144,
    parameter logic [15:0]  SYS_ID    = 16'h1234,
    parameter logic [15:0]  STK_MASK  = 16'hFF00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        wr,
    input  logic        byte_acc,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        nxm,
    input  logic [15:0] mem_err_set,
    input  logic [15:0] cpu_err_set,
    input  logic        hm_load,
    input  logic [15:0] hm_value,
    output logic [15:0] ccr_out,
    output logic [15:0] pirq_out,
    output logic [15:0] stklim_out
);
    localparam logic [15:0] SIZE_VAL = 16'((MEM_BYTES >> 6) - 1);

    logic [SLOT_W-1:0] slot;
    logic              odd;
    logic [NSLOT-1:0]  wstb;
    assign slot = addr[4:1];
    assign odd  = addr[0];

    logic [15:0] memerr_q, ccr_q, hm_q, cpuerr_q, ubrk_q, pirq_q, stk_q;
    logic [15:0] memclr_n, ccr_n, ubrk_n, pirq_n, stk_n;

    sysreg_decode u_dec (
        .req  (req),
        .wr   (wr),
        .slot (slot),
        .wstb (wstb),
        .nxm  (nxm)
    );

    sysreg_lane #(.POLICY(POL_SHIFT))  u_memerr (.cur(memerr_q), .wdata(wdata), .byte_acc(byte_acc), .odd(odd), .nxt(memclr_n));
    sysreg_lane #(.POLICY(POL_MERGE))  u_ccr    (.cur(ccr_q),    .wdata(wdata), .byte_acc(byte_acc), .odd(odd), .nxt(ccr_n));
    sysreg_lane #(.POLICY(POL_IGNORE)) u_ubrk   (.cur(ubrk_q),   .wdata(wdata), .byte_acc(byte_acc), .odd(odd), .nxt(ubrk_n));
    sysreg_lane #(.POLICY(POL_SHIFT))  u_pirq   (.cur(pirq_q),   .wdata(wdata), .byte_acc(byte_acc), .odd(odd), .nxt(pirq_n));
    sysreg_lane #(.POLICY(POL_SHIFT))  u_stk    (.cur(stk_q),    .wdata(wdata), .byte_acc(byte_acc), .odd(odd), .nxt(stk_n));

    // Memory error: clear written ones, then set new status bits.
    always_ff @(posedge clk) begin
        if (!rst_n)               memerr_q <= '0;
        else if (wstb[S_MEMERR])  memerr_q <= (memerr_q & ~memclr_n) | mem_err_set;
        else                      memerr_q <= memerr_q | mem_err_set;
    end

    // CPU error: any write clears, set bits of the same cycle survive.
    always_ff @(posedge clk) begin
        if (!rst_n)               cpuerr_q <= '0;
        else if (wstb[S_CPUERR])  cpuerr_q <= cpu_err_set;
        else                      cpuerr_q <= cpuerr_q | cpu_err_set;
    end

    // Hit/miss: loaded from the cache side only.
    always_ff @(posedge clk) begin
        if (!rst_n)        hm_q <= '0;
        else if (hm_load)  hm_q <= hm_value;
    end

    // Bus-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q  <= '0;
            ubrk_q <= '0;
            pirq_q <= '0;
            stk_q  <= '0;
        end else begin
            if (wstb[S_CCTL])   ccr_q  <= ccr_n;
            if (wstb[S_UBRK])   ubrk_q <= ubrk_n;
            if (wstb[S_IRQ])    pirq_q <= pirq_n;
            if (wstb[S_STKLIM]) stk_q  <= stk_n & STK_MASK;
        end
    end

    // Read multiplexer; absent slots and write cycles read zero.
    always_comb begin
        rdata = '0;
        if (req && !wr) begin
            case (slot)
                S_MEMERR: rdata = memerr_q;
                S_CCTL:   rdata = ccr_q;
                S_HITMS:  rdata = hm_q;
                S_LOSIZE: rdata = SIZE_VAL;
                S_SYSID:  rdata = SYS_ID;
                S_CPUERR: rdata = cpuerr_q;
                S_UBRK:   rdata = ubrk_q;
                S_IRQ:    rdata = pirq_q;
                S_STKLIM: rdata = stk_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign ccr_out    = ccr_q;
    assign pirq_out   = pirq_q;
    assign stklim_out = stk_q;

    // ---------------- assertions ----------------
    p_idle_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !nxm);

    p_hole_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (slot == 4'd6 || slot == 4'd7 || slot == 4'd15)) |-> (nxm && rdata == 16'h0));

    p_ro_write_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && (slot == S_SYSID || slot == S_LOSIZE || slot == S_LOERR)) |-> nxm);

    p_ignore_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && byte_acc && odd && slot == S_UBRK) |=> $stable(ubrk_q));

    p_w1c_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && slot == S_MEMERR && mem_err_set == 16'h0) |=> ((memerr_q & ~$past(memerr_q)) == 16'h0));

    p_cpuerr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && slot == S_CPUERR && cpu_err_set == 16'h0) |=> (cpuerr_q == 16'h0));

    p_stk_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stklim_out[7:0] == 8'h00);
endmodule

// File: tb/sysreg_bank_tb.sv
`timescale 1ns/1ps
module sysreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0, byte_acc = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0, mem_err_set = '0, cpu_err_set = '0, hm_value = '0;
    logic        hm_load = 1'b0;
    logic [15:0] rdata, ccr_out, pirq_out, stklim_out;
    logic        nxm;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_mem, m_ccr, m_hm, m_cpu, m_ubrk, m_pirq, m_stk;

    always #2 clk = ~clk;

    sysreg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .byte_acc(byte_acc),
        .addr(addr), .wdata(wdata), .rdata(rdata), .nxm(nxm),
        .mem_err_set(mem_err_set), .cpu_err_set(cpu_err_set),
        .hm_load(hm_load), .hm_value(hm_value),
        .ccr_out(ccr_out), .pirq_out(pirq_out), .stklim_out(stklim_out)
    );

    function automatic logic [15:0] f_merge(logic [15:0] c, logic [15:0] d, logic b, logic o);
        if (!b) return d;
        return o ? {d[7:0], c[7:0]} : {c[15:8], d[7:0]};
    endfunction
    function automatic logic [15:0] f_shift(logic [15:0] d, logic b, logic o);
        if (!b) return d;
        return o ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
    endfunction
    function automatic logic [15:0] f_ignore(logic [15:0] c, logic [15:0] d, logic b, logic o);
        if (!b) return d;
        return o ? c : {8'h00, d[7:0]};
    endfunction
    function automatic bit f_readable(int s);
        return !(s == 6 || s == 7 || s == 15);
    endfunction
    function automatic bit f_writable(int s);
        return (s >= 2 && s <= 5) || (s >= 11 && s <= 14);
    endfunction
    function automatic logic [15:0] f_read(int s);
        case (s)
            2: return m_mem;   3: return m_ccr;  5: return m_hm;
            8: return 16'h0FFF; 10: return 16'h1234;
            11: return m_cpu;  12: return m_ubrk; 13: return m_pirq;
            14: return m_stk;  default: return 16'h0000;
        endcase
    endfunction
    function automatic string f_tag(int s, bit w);
        if (!f_readable(s)) return "R1";
        if (w && !f_writable(s)) return "R2";
        case (s)
            2: return "R6"; 3: return "R3"; 4, 5: return "R8";
            11: return "R7"; 12: return "R5"; 13: return "R4"; 14: return "R9";
            8, 10: return "R10"; default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mem = 0; m_ccr = 0; m_hm = 0; m_cpu = 0; m_ubrk = 0; m_pirq = 0; m_stk = 0;
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, advance the model.
    task automatic op(bit w, bit b, bit o, int s, logic [15:0] d,
                      logic [15:0] ms, logic [15:0] cs, bit hl, logic [15:0] hv);
        string t;
        @(negedge clk);
        req = 1; wr = w; byte_acc = b; addr = {4'(s), o}; wdata = d;
        mem_err_set = ms; cpu_err_set = cs; hm_load = hl; hm_value = hv;
        #1;
        t = f_tag(s, w);
        check(t, {15'h0, nxm}, {15'h0, w ? !f_writable(s) : !f_readable(s)});
        if (!w) check(t, rdata, f_read(s));
        check("R4", pirq_out, m_pirq);
        check("R9", stklim_out, m_stk);
        check("R3", ccr_out, m_ccr);
        if (w && s == 2) m_mem = (m_mem & ~f_shift(d, b, o)) | ms; else m_mem = m_mem | ms;
        if (w && s == 11) m_cpu = cs; else m_cpu = m_cpu | cs;
        if (hl) m_hm = hv;
        if (w && s == 3)  m_ccr  = f_merge(m_ccr, d, b, o);
        if (w && s == 12) m_ubrk = f_ignore(m_ubrk, d, b, o);
        if (w && s == 13) m_pirq = f_shift(d, b, o);
        if (w && s == 14) m_stk  = f_shift(d, b, o) & 16'hFF00;
    endtask

    task automatic rd(int s);
        op(0, 0, 0, s, 16'h0, 16'h0, 16'h0, 0, 16'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R11: reset state of every slot; nxm quiet while idle
        #1; check("R11", {15'h0, nxm}, 16'h0);
        for (int s = 0; s < 16; s++) rd(s);
        // R1 holes, read and write
        op(1, 0, 0, 7, 16'hFFFF, 0, 0, 0, 0); op(0, 0, 0, 15, 0, 0, 0, 0, 0);
        // R2 read-only writes are refused and change nothing
        op(1, 0, 0, 10, 16'hBEEF, 0, 0, 0, 0); op(1, 0, 0, 8, 16'h0, 0, 0, 0, 0); rd(10); rd(8);
        // R3 merge lanes; R12 same-cycle read sees old value
        op(1, 0, 0, 3, 16'hA5C3, 0, 0, 0, 0);
        op(1, 1, 1, 3, 16'h0077, 0, 0, 0, 0); rd(3);
        op(1, 1, 0, 3, 16'h0011, 0, 0, 0, 0); rd(3);
        // R4 shift-to-high
        op(1, 1, 1, 13, 16'h00E2, 0, 0, 0, 0); rd(13);
        op(1, 1, 0, 13, 16'h00E2, 0, 0, 0, 0); rd(13);
        // R5 ignore odd byte
        op(1, 0, 0, 12, 16'h1357, 0, 0, 0, 0);
        op(1, 1, 1, 12, 16'h00FF, 0, 0, 0, 0); rd(12);
        op(1, 1, 0, 12, 16'h0042, 0, 0, 0, 0); rd(12);
        // R6 W1C, odd byte shifted; set and clear in one cycle
        op(0, 0, 0, 0, 0, 16'hF00F, 0, 0, 0);
        op(1, 1, 1, 2, 16'h0030, 0, 0, 0, 0); rd(2);
        op(1, 0, 0, 2, 16'h0001, 16'h0001, 0, 0, 0); rd(2);
        // R7 any write clears; simultaneous set survives
        op(0, 0, 0, 0, 0, 0, 16'h00C0, 0, 0); rd(11);
        op(1, 1, 1, 11, 16'h0000, 0, 16'h0004, 0, 0); rd(11);
        // R8 hit/miss and maintenance
        op(0, 0, 0, 0, 0, 0, 0, 1, 16'h5A5A);
        op(1, 0, 0, 5, 16'hFFFF, 0, 0, 0, 0); op(1, 0, 0, 4, 16'hFFFF, 0, 0, 0, 0);
        rd(5); rd(4);
        // R9 stack limit mask
        op(1, 0, 0, 14, 16'hABCD, 0, 0, 0, 0); rd(14);
        op(1, 1, 0, 14, 16'h00CD, 0, 0, 0, 0); rd(14);
        // random mix
        for (int k = 0; k < 1500; k++) begin
            bit w, b, o, hl;
            int s;
            logic [15:0] d, ms, cs;
            w = $urandom_range(0, 1); b = $urandom_range(0, 1); o = $urandom_range(0, 1);
            s = $urandom_range(0, 15); d = 16'($urandom);
            ms = ($urandom_range(0, 7) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            cs = ($urandom_range(0, 7) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            hl = ($urandom_range(0, 3) == 0);
            op(w, b, o, s, d, ms, cs, hl, 16'($urandom));
        end
        // R11 reset mid-run clears everything but the ID
        @(negedge clk); req = 0; mem_err_set = 0; cpu_err_set = 0; hm_load = 0; rst_n = 0;
        @(negedge clk); rst_n = 1; model_reset();
        for (int s = 0; s < 16; s++) rd(s);
        @(negedge clk); req = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule